// File: doc/BRIEF.md
# Buck Converter Fault Protection Supervisor

This block sits between the PWM modulator of a synchronous buck converter and its gate drivers. It watches digital flags from the analog comparators (valley over-current once per switching cycle, two over-voltage levels, under-voltage) and decides whether the modulator's high-side and low-side gate requests reach the drivers unchanged or are overridden.

Each fault class has its own recovery policy. Over-current needs a run of consecutive cycle events to trip, and it then holds until power-on reset. Over-voltage switches both its threshold and its latching when soft-start finishes. Under-voltage is filtered by a persistence window and recovers through timed hiccup restarts that the block requests from the start-up sequencer. Sticky status bits record which faults were seen. The power-on-reset flag `por_i` is a synchronous level: while it is high every latch, counter and status bit is cleared.

Top module: `buck_fault_supervisor`

## Requirements
- R1: On each clock edge with `cyc_strobe_i` high, `oc_flag_i` is sampled as one over-current cycle event. When OC_TRIPS (default 4) consecutive events have been sampled, both gate enables go low and `oc_stat_o` goes high after that edge.
- R2: A strobed cycle with `oc_flag_i` low resets the event run, so that OC_TRIPS-1 events, a clean cycle and OC_TRIPS-1 more events do not trip. Edges without a strobe leave the run unchanged.
- R3: An over-current trip holds, with gates low and `oc_stat_o` high, after the flag is removed. Only `por_i` clears it.
- R4: While `ss_done_i` is low, over-voltage follows `ov_lo_flag_i` only and does not latch: the gates are overridden in the same cycle as the flag and return to the requests once it drops. `ov_hi_flag_i` alone has no effect.
- R5: While `ss_done_i` is high, over-voltage follows `ov_hi_flag_i` only and latches until `por_i`. `ov_lo_flag_i` alone has no effect.
- R6: During over-voltage `hs_en_o`=0 and `ls_en_o`=1. This override takes priority over over-current and under-voltage.
- R7: Under-voltage trips only after `uv_flag_i` has been high for UV_DLY_CYC consecutive clocks. A shorter pulse has no effect on the gates or on `uv_stat_o`.
- R8: On an under-voltage trip both gates are held low for HICCUP_CYC clocks. `restart_req_o` then pulses for one clock and the requests pass through again. If the flag persists, the filter and the hiccup repeat.
- R9: `ov_stat_o` and `uv_stat_o` are sticky. They are set one edge after any over-voltage override or under-voltage trip, and `por_i` clears them.
- R10: While `por_i` is high both gate enables are low, and `restart_req_o` and all status bits are zero after the next edge.
- R11: With no fault active, `hs_en_o` equals `hs_req_i` and `ls_en_o` equals `ls_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_i | input | 1 | Power-on-reset level; clears all fault state |
| cyc_strobe_i | input | 1 | One-clock strobe per switching cycle at the valley sample point |
| oc_flag_i | input | 1 | Valley over-current comparator flag |
| ov_lo_flag_i | input | 1 | Over-voltage flag, lower threshold (near 125% of reference) |
| ov_hi_flag_i | input | 1 | Over-voltage flag, upper threshold (near 162.5% of reference) |
| uv_flag_i | input | 1 | Under-voltage comparator flag |
| ss_done_i | input | 1 | Soft-start finished |
| hs_req_i | input | 1 | High-side gate request from the modulator |
| ls_req_i | input | 1 | Low-side gate request from the modulator |
| hs_en_o | output | 1 | Final high-side gate enable |
| ls_en_o | output | 1 | Final low-side gate enable |
| restart_req_o | output | 1 | One-clock restart request to the sequencer |
| oc_stat_o | output | 1 | Over-current latched status |
| ov_stat_o | output | 1 | Sticky over-voltage status |
| uv_stat_o | output | 1 | Sticky under-voltage status |

## Verification
The hardest state to reach is the second pass of the hiccup loop. The under-voltage flag has to stay high through the whole persistence window, the full off-time and the one-clock restart pulse, and then through a second window, with nothing else disturbing it. The bench shortens both windows through parameters. It holds the flag high and counts edges from the moment the flag is raised, so it can check the exact clock on which the gates drop, the exact clock of the restart pulse and the re-trip that follows.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;
  typedef enum logic {
    UV_RUN = 1'b0,
    UV_OFF = 1'b1
  } uv_state_e;

  typedef struct packed {
    logic hs;
    logic ls;
  } gate_pair_t;
endpackage

// File: rtl/fs_oc_filter.sv
module fs_oc_filter #(
  parameter int unsigned TRIPS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic strobe_i,
  input  logic event_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(TRIPS + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      trip_o <= 1'b0;
    end else if (clr_i) begin
      run_q  <= '0;
      trip_o <= 1'b0;
    end else if (strobe_i && !trip_o) begin
      if (!event_i) begin
        run_q <= '0;
      end else if (run_q == CW'(TRIPS - 1)) begin
        run_q  <= '0;
        trip_o <= 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fs_ov_monitor.sv
module fs_ov_monitor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ss_done_i,
  input  logic lo_flag_i,
  input  logic hi_flag_i,
  output logic force_o
);
  logic latch_q;
  logic live;

  // threshold follows soft-start phase
  assign live    = ss_done_i ? hi_flag_i : lo_flag_i;
  assign force_o = latch_q | live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      latch_q <= 1'b0;
    else if (clr_i)                   latch_q <= 1'b0;
    else if (ss_done_i && hi_flag_i)  latch_q <= 1'b1;
  end
endmodule

// File: rtl/fs_uv_hiccup.sv
module fs_uv_hiccup
  import fault_sup_pkg::*;
#(
  parameter int unsigned DLY_CYC    = 1000,
  parameter int unsigned HICCUP_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic uv_i,
  output logic off_o,
  output logic trip_o,
  output logic restart_o
);
  localparam int unsigned DW = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;
  localparam int unsigned HW = (HICCUP_CYC > 1) ? $clog2(HICCUP_CYC) : 1;

  uv_state_e   state_q;
  logic [DW-1:0] dly_q;
  logic [HW-1:0] off_q;
  logic        fire;

  assign fire   = (state_q == UV_RUN) && uv_i && (dly_q == DW'(DLY_CYC - 1));
  assign off_o  = (state_q == UV_OFF);
  assign trip_o = fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= UV_RUN;
      dly_q     <= '0;
      off_q     <= '0;
      restart_o <= 1'b0;
    end else if (clr_i) begin
      state_q   <= UV_RUN;
      dly_q     <= '0;
      off_q     <= '0;
      restart_o <= 1'b0;
    end else begin
      restart_o <= 1'b0;
      unique case (state_q)
        UV_RUN: begin
          if (fire) begin
            state_q <= UV_OFF;
            dly_q   <= '0;
            off_q   <= '0;
          end else if (uv_i) begin
            dly_q <= dly_q + 1'b1;
          end else begin
            dly_q <= '0;
          end
        end
        UV_OFF: begin
          if (off_q == HW'(HICCUP_CYC - 1)) begin
            state_q   <= UV_RUN;
            off_q     <= '0;
            restart_o <= 1'b1;
          end else begin
            off_q <= off_q + 1'b1;
          end
        end
        default: state_q <= UV_RUN;
      endcase
    end
  end
endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor
  import fault_sup_pkg::*;
#(
  parameter int unsigned OC_TRIPS   = 4,
  parameter int unsigned UV_DLY_CYC = 1000,
  parameter int unsigned HICCUP_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic cyc_strobe_i,
  input  logic oc_flag_i,
  input  logic ov_lo_flag_i,
  input  logic ov_hi_flag_i,
  input  logic uv_flag_i,
  input  logic ss_done_i,
  input  logic hs_req_i,
  input  logic ls_req_i,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic restart_req_o,
  output logic oc_stat_o,
  output logic ov_stat_o,
  output logic uv_stat_o
);
  logic oc_trip, ov_force, uv_off, uv_trip;
  logic ov_stat_q, uv_stat_q;
  gate_pair_t gate;

  fs_oc_filter #(.TRIPS(OC_TRIPS)) u_oc (
    .clk_i, .rst_ni, .clr_i(por_i), .strobe_i(cyc_strobe_i),
    .event_i(oc_flag_i), .trip_o(oc_trip)
  );

  fs_ov_monitor u_ov (
    .clk_i, .rst_ni, .clr_i(por_i), .ss_done_i,
    .lo_flag_i(ov_lo_flag_i), .hi_flag_i(ov_hi_flag_i), .force_o(ov_force)
  );

  fs_uv_hiccup #(.DLY_CYC(UV_DLY_CYC), .HICCUP_CYC(HICCUP_CYC)) u_uv (
    .clk_i, .rst_ni, .clr_i(por_i), .uv_i(uv_flag_i),
    .off_o(uv_off), .trip_o(uv_trip), .restart_o(restart_req_o)
  );

  // priority: POR, then OV discharge, then OC/UV off
  always_comb begin
    if (por_i)                gate = '{hs: 1'b0, ls: 1'b0};
    else if (ov_force)        gate = '{hs: 1'b0, ls: 1'b1};
    else if (oc_trip || uv_off) gate = '{hs: 1'b0, ls: 1'b0};
    else                      gate = '{hs: hs_req_i, ls: ls_req_i};
  end

  assign hs_en_o = gate.hs;
  assign ls_en_o = gate.ls;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_stat_q <= 1'b0;
      uv_stat_q <= 1'b0;
    end else if (por_i) begin
      ov_stat_q <= 1'b0;
      uv_stat_q <= 1'b0;
    end else begin
      ov_stat_q <= ov_stat_q | ov_force;
      uv_stat_q <= uv_stat_q | uv_trip;
    end
  end

  assign oc_stat_o = oc_trip;
  assign ov_stat_o = ov_stat_q;
  assign uv_stat_o = uv_stat_q;
endmodule

// File: rtl/fault_sup_checker.sv
module fault_sup_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic por_i,
  input logic ov_hi_flag_i,
  input logic ss_done_i,
  input logic hs_en_o,
  input logic ls_en_o,
  input logic restart_req_o,
  input logic oc_stat_o,
  input logic ov_stat_o,
  input logic uv_stat_o
);
  AST_POR_GATES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |-> (!hs_en_o && !ls_en_o)); // R10

  AST_OC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_stat_o && !por_i) |=> oc_stat_o); // R3

  AST_OC_HS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_stat_o |-> !hs_en_o); // R1

  AST_OV_DISCHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_done_i && ov_hi_flag_i && !por_i) |-> (!hs_en_o && ls_en_o)); // R6

  AST_RESTART_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_req_o |=> !restart_req_o); // R8

  AST_STAT_POR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (!oc_stat_o && !ov_stat_o && !uv_stat_o && !restart_req_o)); // R9
endmodule

bind buck_fault_supervisor fault_sup_checker u_fault_sup_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .por_i        (por_i),
  .ov_hi_flag_i (ov_hi_flag_i),
  .ss_done_i    (ss_done_i),
  .hs_en_o      (hs_en_o),
  .ls_en_o      (ls_en_o),
  .restart_req_o(restart_req_o),
  .oc_stat_o    (oc_stat_o),
  .ov_stat_o    (ov_stat_o),
  .uv_stat_o    (uv_stat_o)
);

// File: tb/sim_buck_fault_supervisor.sv
`timescale 1ns/1ps
module sim_buck_fault_supervisor;
  localparam int unsigned UV_DLY = 8;
  localparam int unsigned HIC    = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic por = 1'b1, strobe = 1'b0, oc = 1'b0, ovl = 1'b0, ovh = 1'b0, uv = 1'b0;
  logic ss = 1'b0, hsr = 1'b0, lsr = 1'b0;
  logic hs_en, ls_en, rst_req, oc_st, ov_st, uv_st;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  buck_fault_supervisor #(.OC_TRIPS(4), .UV_DLY_CYC(UV_DLY), .HICCUP_CYC(HIC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .por_i(por), .cyc_strobe_i(strobe),
    .oc_flag_i(oc), .ov_lo_flag_i(ovl), .ov_hi_flag_i(ovh), .uv_flag_i(uv),
    .ss_done_i(ss), .hs_req_i(hsr), .ls_req_i(lsr),
    .hs_en_o(hs_en), .ls_en_o(ls_en), .restart_req_o(rst_req),
    .oc_stat_o(oc_st), .ov_stat_o(ov_st), .uv_stat_o(uv_st)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic do_por();
    por = 1'b1; #1;
    chk("R10", "hs during por", hs_en, 1'b0);
    chk("R10", "ls during por", ls_en, 1'b0);
    tick(1);
    chk("R10", "oc_stat after por", oc_st, 1'b0);
    chk("R9", "ov_stat after por", ov_st, 1'b0);
    chk("R9", "uv_stat after por", uv_st, 1'b0);
    por = 1'b0; tick(1);
  endtask

  task automatic pulse_strobe(input logic ev);
    oc = ev; strobe = 1'b1; tick(1); strobe = 1'b0; tick(2);
  endtask

  task automatic t_reset();
    chk("R10", "reset restart", rst_req, 1'b0);
    chk("R10", "reset oc_stat", oc_st, 1'b0);
    chk("R9", "reset ov_stat", ov_st, 1'b0);
    chk("R9", "reset uv_stat", uv_st, 1'b0);
  endtask

  task automatic t_pass();
    hsr = 1'b1; lsr = 1'b0; #1;
    chk("R11", "pass hs", hs_en, 1'b1); chk("R11", "pass ls", ls_en, 1'b0);
    hsr = 1'b0; lsr = 1'b1; #1;
    chk("R11", "pass hs2", hs_en, 1'b0); chk("R11", "pass ls2", ls_en, 1'b1);
  endtask

  task automatic t_oc_trip();
    hsr = 1'b1; lsr = 1'b0;
    for (int i = 0; i < 3; i++) pulse_strobe(1'b1);
    chk("R1", "oc_stat after 3", oc_st, 1'b0);
    chk("R1", "hs after 3", hs_en, 1'b1);
    oc = 1'b1; strobe = 1'b1; tick(1); strobe = 1'b0;
    chk("R1", "oc_stat after 4", oc_st, 1'b1);
    chk("R1", "hs after 4", hs_en, 1'b0);
    lsr = 1'b1; #1;
    chk("R1", "ls after 4", ls_en, 1'b0);
    oc = 1'b0; pulse_strobe(1'b0); tick(5);
    chk("R3", "oc held", oc_st, 1'b1);
    chk("R3", "hs held low", hs_en, 1'b0);
    // OV wins over latched OC
    ovl = 1'b1; #1;
    chk("R6", "ov prio hs", hs_en, 1'b0);
    chk("R6", "ov prio ls", ls_en, 1'b1);
    ovl = 1'b0; lsr = 1'b0;
    do_por();
    chk("R3", "hs free after por", hs_en, 1'b1);
  endtask

  task automatic t_oc_gap();
    hsr = 1'b1;
    for (int i = 0; i < 3; i++) pulse_strobe(1'b1);
    oc = 1'b1; tick(3); // unstrobed edges with flag high do not count
    pulse_strobe(1'b0);
    for (int i = 0; i < 3; i++) pulse_strobe(1'b1);
    chk("R2", "no trip after gap", oc_st, 1'b0);
    chk("R2", "hs after gap", hs_en, 1'b1);
    pulse_strobe(1'b1);
    chk("R2", "trip on 4th after gap", oc_st, 1'b1);
    oc = 1'b0;
    do_por();
  endtask

  task automatic t_ov_soft();
    ss = 1'b0; hsr = 1'b1; lsr = 1'b0;
    ovh = 1'b1; #1;
    chk("R4", "hi ignored pre-ss", hs_en, 1'b1);
    ovh = 1'b0; ovl = 1'b1; #1;
    chk("R4", "pre-ss ov hs", hs_en, 1'b0);
    chk("R4", "pre-ss ov ls", ls_en, 1'b1);
    tick(3); ovl = 1'b0; #1;
    chk("R4", "pre-ss recover hs", hs_en, 1'b1);
    chk("R4", "pre-ss recover ls", ls_en, 1'b0);
    chk("R9", "ov sticky", ov_st, 1'b1);
    do_por();
  endtask

  task automatic t_ov_latch();
    ss = 1'b1; hsr = 1'b1; lsr = 1'b0;
    ovl = 1'b1; #1;
    chk("R5", "lo ignored post-ss", hs_en, 1'b1);
    tick(2);
    chk("R5", "no ov stat from lo", ov_st, 1'b0);
    ovl = 1'b0; ovh = 1'b1; #1;
    chk("R6", "post-ss hs", hs_en, 1'b0);
    chk("R6", "post-ss ls", ls_en, 1'b1);
    tick(1); ovh = 1'b0; tick(4);
    chk("R5", "latched hs", hs_en, 1'b0);
    chk("R5", "latched ls", ls_en, 1'b1);
    do_por();
    chk("R5", "released hs", hs_en, 1'b1);
    ss = 1'b0;
  endtask

  task automatic t_uv_short();
    hsr = 1'b1; lsr = 1'b0;
    uv = 1'b1; tick(UV_DLY - 1); uv = 1'b0; tick(3);
    chk("R7", "short uv hs", hs_en, 1'b1);
    chk("R7", "short uv stat", uv_st, 1'b0);
  endtask

  task automatic t_uv_hiccup();
    hsr = 1'b1; lsr = 1'b1;
    uv = 1'b1; tick(UV_DLY - 1);
    chk("R7", "before window hs", hs_en, 1'b1);
    tick(1);
    chk("R8", "uv off hs", hs_en, 1'b0);
    chk("R8", "uv off ls", ls_en, 1'b0);
    chk("R9", "uv sticky", uv_st, 1'b1);
    tick(HIC - 1);
    chk("R8", "still off", hs_en, 1'b0);
    chk("R8", "no early restart", rst_req, 1'b0);
    tick(1);
    chk("R8", "restart pulse", rst_req, 1'b1);
    chk("R8", "resume hs", hs_en, 1'b1);
    tick(1);
    chk("R8", "restart one clk", rst_req, 1'b0);
    tick(UV_DLY - 1);
    chk("R8", "second trip", hs_en, 1'b0);
    uv = 1'b0;
    do_por();
    chk("R10", "uv cleared hs", hs_en, 1'b1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    por = 1'b0;
    tick(1);
    t_reset();
    t_pass();
    t_oc_trip();
    t_oc_gap();
    t_ov_soft();
    t_ov_latch();
    t_uv_short();
    t_uv_hiccup();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule